// File: doc/BRIEF.md
# Auxiliary Memory Bank Switch Controller

This block watches a 16-bit address, 8-bit data processor bus and decodes accesses that fall in one 256-byte page of memory-mapped mode switches. A few of those accesses set or clear the mode flags: 80-column store, second display page, high-resolution graphics, auxiliary read, auxiliary write and mixed display. From the flags it drives bank selects that choose main (0) or auxiliary (1) memory. There are separate selects for reads and for writes, for the text window and for the graphics window. It also drives the number of the page on display.

When the 80-column store flag is clear, the read selects follow the auxiliary-read flag and the write selects follow the auxiliary-write flag, and the page-2 flag picks the displayed page. When the store flag is set, page-2 picks the bank of the text window instead. It also picks the bank of the graphics window while graphics mode is on. The displayed page is then held at 0. With graphics mode off, the graphics window keeps whatever bank it last had. Status reads return one flag in bit 7 of the data, registered one cycle after the read.

Top module: `aux_bank_ctrl`

## Requirements
- R1: After reset every flag is 0. All four bank selects are 0 (main), `disp_page` is 0, `mix_mode` is 0 and `bus_rdata` is 0x00.
- R2: A write to switch offset 0x01 sets the 80-column store flag, and a write to offset 0x00 clears it. Reads of these offsets change nothing.
- R3: Writes to offsets 0x02 and 0x03 clear and set auxiliary-read. Writes to 0x04 and 0x05 clear and set auxiliary-write. Reads of 0x02 to 0x05 change nothing.
- R4: A read or a write at offset 0x52 or 0x53 clears or sets the mixed flag (`mix_mode`). At 0x54 or 0x55 it clears or sets page-2, and at 0x56 or 0x57 it clears or sets graphics mode.
- R5: A read of a status offset returns its flag in bit 7 with bits 6..0 zero, on `bus_rdata` in the cycle after the read. The status offsets are 0x18 (store), 0x13 (auxiliary-read), 0x14 (auxiliary-write), 0x1C (page-2) and 0x1D (graphics). In the cycle after any other cycle, `bus_rdata` is 0x00. A status read changes no flag.
- R6: While the store flag is set, `rd_text_aux` and `wr_text_aux` both equal the page-2 flag.
- R7: While the store flag and graphics mode are both set, `rd_hgr_aux` and `wr_hgr_aux` both equal the page-2 flag.
- R8: While the store flag is set and graphics mode is clear, `rd_hgr_aux` and `wr_hgr_aux` hold their values. Changes to page-2, auxiliary-read and auxiliary-write do not move them.
- R9: While the store flag is set, `disp_page` is 0 whatever page-2 is.
- R10: While the store flag is clear, `rd_text_aux` and `rd_hgr_aux` equal auxiliary-read, and `wr_text_aux` and `wr_hgr_aux` equal auxiliary-write.
- R11: While the store flag is clear, `disp_page` equals the page-2 flag.
- R12: Every output reflects an access in the clock cycle that follows it.
- R13: Idle cycles and accesses outside the switch page (address bits 15..8 other than 0xC0) change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| bus_rdata | output | 8 | Registered status data |
| rd_text_aux | output | 1 | Text window read bank (1 = auxiliary) |
| wr_text_aux | output | 1 | Text window write bank |
| rd_hgr_aux | output | 1 | Graphics window read bank |
| wr_hgr_aux | output | 1 | Graphics window write bank |
| disp_page | output | 1 | Displayed page number |
| mix_mode | output | 1 | Mixed display flag |

## Verification
The edge that latches a new store flag is also the edge at which the graphics-window bank register either captures its value or freezes. Take an access that sets the store flag while graphics mode is off and auxiliary-read is on. The graphics select must keep the auxiliary bank it had just before, while the text select jumps to follow page-2. The bench provokes this with that exact sequence. It then toggles auxiliary-read and page-2 and checks that the graphics selects never move. A scoreboard model compares every output, one cycle after each access, against a prediction built only from the requirements.

// File: rtl/aux_bank_pkg.sv
package aux_bank_pkg;
  typedef struct packed {
    logic s80;
    logic rd_aux;
    logic wr_aux;
    logic pg2;
    logic hires;
    logic mixed;
  } mode_t;

  // switch offsets inside the page
  localparam logic [7:0] OFF_S80_CLR = 8'h00;
  localparam logic [7:0] OFF_S80_SET = 8'h01;
  localparam logic [7:0] OFF_RDA_CLR = 8'h02;
  localparam logic [7:0] OFF_RDA_SET = 8'h03;
  localparam logic [7:0] OFF_WRA_CLR = 8'h04;
  localparam logic [7:0] OFF_WRA_SET = 8'h05;
  localparam logic [7:0] OFF_MIX_CLR = 8'h52;
  localparam logic [7:0] OFF_MIX_SET = 8'h53;
  localparam logic [7:0] OFF_PG2_CLR = 8'h54;
  localparam logic [7:0] OFF_PG2_SET = 8'h55;
  localparam logic [7:0] OFF_HGR_CLR = 8'h56;
  localparam logic [7:0] OFF_HGR_SET = 8'h57;
  // status offsets
  localparam logic [7:0] OFF_ST_RDA = 8'h13;
  localparam logic [7:0] OFF_ST_WRA = 8'h14;
  localparam logic [7:0] OFF_ST_S80 = 8'h18;
  localparam logic [7:0] OFF_ST_PG2 = 8'h1C;
  localparam logic [7:0] OFF_ST_HGR = 8'h1D;
endpackage

// File: rtl/aux_sw_decode.sv
module aux_sw_decode
  import aux_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'hC000
) (
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  mode_t             cur,
  output mode_t             nxt,
  output logic              stat_hit,
  output logic              stat_bit
);
  localparam int OFF_W = 8;

  logic             in_page;
  logic [OFF_W-1:0] off;

  assign in_page = bus_valid && (bus_addr[ADDR_W-1:OFF_W] == PAGE_BASE[ADDR_W-1:OFF_W]);
  assign off     = bus_addr[OFF_W-1:0];

  always_comb begin
    nxt = cur;
    if (in_page && bus_we) begin
      case (off)
        OFF_S80_CLR: nxt.s80    = 1'b0;
        OFF_S80_SET: nxt.s80    = 1'b1;
        OFF_RDA_CLR: nxt.rd_aux = 1'b0;
        OFF_RDA_SET: nxt.rd_aux = 1'b1;
        OFF_WRA_CLR: nxt.wr_aux = 1'b0;
        OFF_WRA_SET: nxt.wr_aux = 1'b1;
        default: ;
      endcase
    end
    if (in_page) begin
      case (off)
        OFF_MIX_CLR: nxt.mixed = 1'b0;
        OFF_MIX_SET: nxt.mixed = 1'b1;
        OFF_PG2_CLR: nxt.pg2   = 1'b0;
        OFF_PG2_SET: nxt.pg2   = 1'b1;
        OFF_HGR_CLR: nxt.hires = 1'b0;
        OFF_HGR_SET: nxt.hires = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    stat_hit = 1'b0;
    stat_bit = 1'b0;
    if (in_page && !bus_we) begin
      stat_hit = 1'b1;
      case (off)
        OFF_ST_RDA: stat_bit = cur.rd_aux;
        OFF_ST_WRA: stat_bit = cur.wr_aux;
        OFF_ST_S80: stat_bit = cur.s80;
        OFF_ST_PG2: stat_bit = cur.pg2;
        OFF_ST_HGR: stat_bit = cur.hires;
        default:    stat_hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/aux_bank_route.sv
module aux_bank_route
  import aux_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t cur,
  input  mode_t nxt,
  output logic  rd_text_aux,
  output logic  wr_text_aux,
  output logic  rd_hgr_aux,
  output logic  wr_hgr_aux,
  output logic  disp_page
);
  localparam int NDIR = 2; // index 0 = read, 1 = write

  logic [NDIR-1:0] aux_now, aux_nxt, text_sel, hgr_q;

  assign aux_now = {cur.wr_aux, cur.rd_aux};
  assign aux_nxt = {nxt.wr_aux, nxt.rd_aux};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign text_sel[d] = cur.s80 ? cur.pg2 : aux_now[d];

    // graphics window bank: computed from the next flags so it lines up
    // with the flag register, and frozen while store is on without graphics
    always_ff @(posedge clk) begin
      if (rst)
        hgr_q[d] <= 1'b0;
      else if (nxt.s80 && nxt.hires)
        hgr_q[d] <= nxt.pg2;
      else if (!nxt.s80)
        hgr_q[d] <= aux_nxt[d];
    end
  end

  assign rd_text_aux = text_sel[0];
  assign wr_text_aux = text_sel[1];
  assign rd_hgr_aux  = hgr_q[0];
  assign wr_hgr_aux  = hgr_q[1];
  assign disp_page   = cur.pg2 && !cur.s80;
endmodule

// File: rtl/aux_status_port.sv
module aux_status_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_hit,
  input  logic              stat_bit,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (stat_hit)
      rdata <= {stat_bit, {(DATA_W-1){1'b0}}};
    else
      rdata <= '0;
  end
endmodule

// File: rtl/aux_bank_ctrl.sv
module aux_bank_ctrl
  import aux_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'hC000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rd_text_aux,
  output logic              wr_text_aux,
  output logic              rd_hgr_aux,
  output logic              wr_hgr_aux,
  output logic              disp_page,
  output logic              mix_mode
);
  mode_t mode_q, mode_d;
  logic  stat_hit, stat_bit;

  aux_sw_decode #(.ADDR_W(ADDR_W), .PAGE_BASE(PAGE_BASE)) u_dec (
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .cur       (mode_q),
    .nxt       (mode_d),
    .stat_hit  (stat_hit),
    .stat_bit  (stat_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else     mode_q <= mode_d;
  end

  aux_bank_route u_route (
    .clk         (clk),
    .rst         (rst),
    .cur         (mode_q),
    .nxt         (mode_d),
    .rd_text_aux (rd_text_aux),
    .wr_text_aux (wr_text_aux),
    .rd_hgr_aux  (rd_hgr_aux),
    .wr_hgr_aux  (wr_hgr_aux),
    .disp_page   (disp_page)
  );

  aux_status_port #(.DATA_W(DATA_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .stat_hit (stat_hit),
    .stat_bit (stat_bit),
    .rdata    (bus_rdata)
  );

  assign mix_mode = mode_q.mixed;
endmodule

// File: rtl/aux_bank_chk.sv
module aux_bank_chk
  import aux_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'hC000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input mode_t             mode,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rd_hgr_aux,
  input logic              wr_hgr_aux,
  input logic              disp_page
);
  localparam logic [ADDR_W-1:0] A_S80_SET = PAGE_BASE + ADDR_W'(8'h01);
  localparam logic [ADDR_W-1:0] A_ST_S80  = PAGE_BASE + ADDR_W'(8'h18);

  assert_store_set_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we && bus_addr == A_S80_SET) |=> mode.s80);

  assert_status_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && bus_addr == A_ST_S80)
      |=> (bus_rdata[DATA_W-1] == $past(mode.s80)) && $stable(mode));

  assert_hgr_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (mode.s80 && mode.hires) |-> (rd_hgr_aux == mode.pg2 && wr_hgr_aux == mode.pg2));

  assert_hgr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode.s80 && !mode.hires)
      |=> (!(mode.s80 && !mode.hires) || ($stable(rd_hgr_aux) && $stable(wr_hgr_aux))));

  assert_page_zero_R9: assert property (@(posedge clk) disable iff (rst)
    mode.s80 |-> !disp_page);

  assert_hgr_plain_R10: assert property (@(posedge clk) disable iff (rst)
    !mode.s80 |-> (rd_hgr_aux == mode.rd_aux && wr_hgr_aux == mode.wr_aux));

  assert_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> $stable(mode));
endmodule

bind aux_bank_ctrl aux_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BASE(PAGE_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .mode       (mode_q),
  .bus_rdata  (bus_rdata),
  .rd_hgr_aux (rd_hgr_aux),
  .wr_hgr_aux (wr_hgr_aux),
  .disp_page  (disp_page)
);

// File: tb/tb_aux_bank_ctrl.sv
`timescale 1ns/1ps
module tb_aux_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_rdata;
  logic rd_text_aux, wr_text_aux, rd_hgr_aux, wr_hgr_aux, disp_page, mix_mode;

  aux_bank_ctrl dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .rd_text_aux(rd_text_aux), .wr_text_aux(wr_text_aux),
    .rd_hgr_aux(rd_hgr_aux), .wr_hgr_aux(wr_hgr_aux),
    .disp_page(disp_page), .mix_mode(mix_mode)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // scoreboard: {rd_text, wr_text, rd_hgr, wr_hgr, disp, mix, rdata[7:0]}
  logic [13:0] exp_q[$];
  string       tag_q[$];

  // reference model state
  logic m_s80 = 0, m_rda = 0, m_wra = 0, m_pg2 = 0, m_hgr = 0, m_mix = 0;
  logic m_hrd = 0, m_hwr = 0;

  function automatic logic [13:0] predict(input logic [7:0] rd);
    logic trd, twr;
    trd = m_s80 ? m_pg2 : m_rda;
    twr = m_s80 ? m_pg2 : m_wra;
    return {trd, twr, m_hrd, m_hwr, (m_pg2 & ~m_s80), m_mix, rd};
  endfunction

  task automatic acc(input logic [15:0] a, input logic w, input string tag);
    logic [7:0] rd;
    logic [7:0] o;
    bit inp;
    o   = a[7:0];
    inp = (a[15:8] == 8'hC0);
    rd  = 8'h00;
    bus_addr  = a;
    bus_we    = w;
    bus_valid = 1'b1;
    if (inp && !w) begin
      case (o)
        8'h13: rd = {m_rda, 7'b0};
        8'h14: rd = {m_wra, 7'b0};
        8'h18: rd = {m_s80, 7'b0};
        8'h1C: rd = {m_pg2, 7'b0};
        8'h1D: rd = {m_hgr, 7'b0};
        default: rd = 8'h00;
      endcase
    end
    if (inp && w) begin
      case (o)
        8'h00: m_s80 = 0;  8'h01: m_s80 = 1;
        8'h02: m_rda = 0;  8'h03: m_rda = 1;
        8'h04: m_wra = 0;  8'h05: m_wra = 1;
        default: ;
      endcase
    end
    if (inp) begin
      case (o)
        8'h52: m_mix = 0;  8'h53: m_mix = 1;
        8'h54: m_pg2 = 0;  8'h55: m_pg2 = 1;
        8'h56: m_hgr = 0;  8'h57: m_hgr = 1;
        default: ;
      endcase
    end
    if (m_s80 && m_hgr) begin
      m_hrd = m_pg2; m_hwr = m_pg2;
    end else if (!m_s80) begin
      m_hrd = m_rda; m_hwr = m_wra;
    end
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
    exp_q.push_back(predict(rd));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(posedge clk);
    #1;
    exp_q.push_back(predict(8'h00));
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      logic [13:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {rd_text_aux, wr_text_aux, rd_hgr_aux, wr_hgr_aux, disp_page, mix_mode, bus_rdata};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s actual=%b expected=%b", t, a, e);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [7:0] offs [0:15];
    offs = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h13, 8'h14,
             8'h18, 8'h1C, 8'h1D, 8'h52, 8'h53, 8'h54, 8'h55, 8'h56};
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    exp_q.push_back(14'd0); tag_q.push_back("R1 reset");
    @(negedge clk);

    acc(16'hC018, 0, "R5 status clear");
    acc(16'hC001, 1, "R2 store on");
    acc(16'hC018, 0, "R5 status set");
    acc(16'hC018, 0, "R5 read twice no change");
    acc(16'hC001, 0, "R2 read of 0x01 no effect");
    acc(16'hC055, 1, "R6 R9 page2 on text aux");
    acc(16'hC054, 0, "R4 read clears page2");
    acc(16'hC057, 1, "R7 hires on");
    acc(16'hC055, 0, "R7 hires follow page2");
    acc(16'hC056, 1, "R8 hires off hold");
    acc(16'hC054, 1, "R8 page2 off hold");
    acc(16'hC003, 1, "R8 rd aux no move");
    acc(16'hC000, 1, "R10 store off");
    acc(16'hC055, 1, "R11 page shown 1");
    acc(16'hC002, 1, "R3 rd aux clr");
    acc(16'hC005, 1, "R3 wr aux set");
    acc(16'hC003, 0, "R3 read no effect");
    acc(16'hC004, 1, "R3 wr aux clr");
    acc(16'hC101, 1, "R13 other page");
    acc(16'h0001, 1, "R13 low memory");
    idle("R13 idle");
    acc(16'hC053, 0, "R4 mixed on by read");
    acc(16'hC052, 1, "R4 mixed off by write");
    acc(16'hC057, 0, "R4 hires on by read");
    acc(16'hC01D, 0, "R5 status hires");
    acc(16'hC01C, 0, "R5 status page2");
    // latch versus store-on in one edge
    acc(16'hC056, 1, "R8 hires off");
    acc(16'hC003, 1, "R10 rd aux set");
    acc(16'hC001, 1, "R8 capture at store on");
    acc(16'hC002, 1, "R8 rd aux clr hold");
    acc(16'hC054, 1, "R6 text follows page2");
    acc(16'hC013, 0, "R5 status rd aux");
    acc(16'hC014, 0, "R5 status wr aux");
    acc(16'hC000, 1, "R10 store off release");

    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      acc({8'hC0, offs[lfsr[3:0]] | {7'b0, (lfsr[3:0] == 4'hF) & lfsr[6]}},
          lfsr[5], "R12 random walk");
    end

    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule